// File: doc/BRIEF.md
# Dual Data Pointer Register Bank

This block holds two 16-bit data pointers for an 8051-style core and exposes them through the core's special function register (SFR) bus. A one-bit select register picks the active pointer. The core's usual pointer low/high SFRs always reach whichever pointer is active. The second pointer also has two byte addresses of its own, so software can load it without switching the selection. The active 16-bit pointer value is driven out as the address for memory accesses.

The core sends pointer update requests to the block: increment, decrement, store-with-post-increment and a plain pointer access. A pointer access can trigger an automatic step of +1, +2, -1 or -2, set by a small mode register. The mode register can also flip the select bit after each access. Pointer arithmetic wraps modulo 2^16. A parameter moves the select register to an alternative SFR address. The number of pointers is held at two, because more pointers add interrupt-latency cost for little gain.

Top module: `dptr_pair_bank`

## Requirements
- R1: After reset both pointers are 0x0000, the select bit is 0 and all mode bits are 0, so `ptr_addr` reads 0x0000.
- R2: Bit 0 of the select SFR chooses the active pointer: 0 selects pointer 0 and 1 selects pointer 1. The select SFR is at 0x86, or at 0xA2 when `ALT_MAP` is 1. Reads return the bit in position 0 with zeros above it, and writes to bits 7:1 are ignored.
- R3: SFR 0x82 (low byte) and SFR 0x83 (high byte) read and write the currently active pointer.
- R4: SFR 0x84 (low byte) and SFR 0x85 (high byte) always read and write pointer 1, whatever the select bit holds.
- R5: An increment request adds 1 to the active pointer at the next clock edge, and 0xFFFF wraps to 0x0000.
- R6: A decrement request subtracts 1 from the active pointer at the next clock edge, and 0x0000 wraps to 0xFFFF.
- R7: A store-with-post-increment request adds exactly 1 to the active pointer, whatever the mode register holds.
- R8: The mode register at SFR 0x93 has four fields. Bit 0 enables the auto-step, bit 1 sets the direction (1 = down), bit 2 sets the step size (1 = two, 0 = one) and bit 3 enables auto-toggle. An access request steps the active pointer only when bit 0 is set. Reads return bits 3:0 with zeros above them.
- R9: When mode bit 3 is set, an access request flips the select bit at the same edge. Any auto-step applies to the pointer that was active during the access.
- R10: A write to an SFR byte of a pointer in the same cycle as an update request for that pointer wins. The written byte takes the new data, the other byte keeps its value, and no step is applied. A write to the select SFR likewise overrides an auto-toggle in the same cycle.
- R11: `ptr_addr` always shows the active pointer. `sfr_hit` is 1 exactly when `sfr_addr` is one of the block's six SFR addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | SFR address for the read or write |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | DATA_W | SFR write data |
| sfr_rdata | output | DATA_W | SFR read data (combinational) |
| sfr_hit | output | 1 | Address belongs to this block |
| req_inc | input | 1 | Increment the active pointer |
| req_dec | input | 1 | Decrement the active pointer |
| req_store_inc | input | 1 | Store through pointer, then add 1 |
| req_access | input | 1 | Pointer access; applies the auto-step and auto-toggle |
| ptr_addr | output | PTR_W | Active pointer value |

## Verification
The assertions assume that at most one of the four request inputs is high in any cycle. They also assume that an SFR write does not coincide with a request unless the test is exercising the write-wins rule. Every bench task raises a single request line per cycle. The only place a write and a request share a cycle is the conflict task, and there the expected value follows the write-wins rule. A second instance with the alternative select mapping is driven only through its SFR port.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
   // Fixed SFR map of the pointer bank
   localparam logic [7:0] ADR_PLO     = 8'h82;
   localparam logic [7:0] ADR_PHI     = 8'h83;
   localparam logic [7:0] ADR_P1LO    = 8'h84;
   localparam logic [7:0] ADR_P1HI    = 8'h85;
   localparam logic [7:0] ADR_SEL     = 8'h86;
   localparam logic [7:0] ADR_SEL_ALT = 8'hA2;
   localparam logic [7:0] ADR_MODE    = 8'h93;

   localparam int unsigned NUM_PTR  = 2;
   localparam int unsigned MODE_W   = 4;

   typedef struct packed {
      logic toggle;   // bit 3
      logic step2;    // bit 2
      logic down;     // bit 1
      logic auto_en;  // bit 0
   } dpb_mode_t;
endpackage

// File: rtl/dpb_decode.sv
module dpb_decode
   import dpb_pkg::*;
#(
   parameter bit ALT_MAP = 1'b0
) (
   input  logic [7:0]         addr,
   input  logic               wr,
   input  logic               sel,
   output logic               hit_lo,
   output logic               hit_hi,
   output logic               hit_p1lo,
   output logic               hit_p1hi,
   output logic               hit_sel,
   output logic               hit_mode,
   output logic               hit_any,
   output logic [NUM_PTR-1:0] wr_lo,
   output logic [NUM_PTR-1:0] wr_hi,
   output logic               wr_sel,
   output logic               wr_mode
);
   assign hit_lo   = (addr == ADR_PLO);
   assign hit_hi   = (addr == ADR_PHI);
   assign hit_p1lo = (addr == ADR_P1LO);
   assign hit_p1hi = (addr == ADR_P1HI);
   assign hit_mode = (addr == ADR_MODE);

   generate
      if (ALT_MAP) begin : g_sel_alt
         assign hit_sel = (addr == ADR_SEL_ALT);
      end else begin : g_sel_std
         assign hit_sel = (addr == ADR_SEL);
      end
   endgenerate

   assign hit_any = hit_lo | hit_hi | hit_p1lo | hit_p1hi | hit_sel | hit_mode;

   assign wr_lo[0] = wr & hit_lo & ~sel;
   assign wr_hi[0] = wr & hit_hi & ~sel;
   assign wr_lo[1] = wr & ((hit_lo & sel) | hit_p1lo);
   assign wr_hi[1] = wr & ((hit_hi & sel) | hit_p1hi);
   assign wr_sel   = wr & hit_sel;
   assign wr_mode  = wr & hit_mode;
endmodule

// File: rtl/dpb_ptr.sv
module dpb_ptr #(
   parameter int unsigned PTR_W  = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              step_en,
   input  logic [PTR_W-1:0]  step_val,
   output logic [PTR_W-1:0]  value
);
   localparam int unsigned HI_W = PTR_W - DATA_W;

   generate
      if (PTR_W != 2 * DATA_W) begin : g_bad_width
         $error("dpb_ptr: PTR_W must be twice DATA_W");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         value <= '0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) value[DATA_W-1:0]     <= wdata;
         if (wr_hi) value[PTR_W-1:DATA_W] <= wdata[HI_W-1:0];
      end else if (step_en) begin
         value <= value + step_val;
      end
   end

   // Step result wraps modulo 2^PTR_W
   assert_step_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !wr_lo && !wr_hi) |=> (value == $past(value + step_val)));

   // Write beats a step, other byte held
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> (value[DATA_W-1:0] == $past(wdata)
                             && value[PTR_W-1:DATA_W] == $past(value[PTR_W-1:DATA_W])));

   assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_lo && !wr_hi && !step_en) |=> $stable(value));
endmodule

// File: rtl/dpb_ctl.sv
module dpb_ctl
   import dpb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel_wr,
   input  logic        sel_din,
   input  logic        mode_wr,
   input  logic [MODE_W-1:0] mode_din,
   input  logic        access,
   output logic        sel,
   output dpb_mode_t   mode
);
   logic flip;
   assign flip = access & mode.toggle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= 1'b0;
      end else if (sel_wr) begin
         sel <= sel_din;
      end else if (flip) begin
         sel <= ~sel;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (mode_wr) begin
         mode <= dpb_mode_t'(mode_din);
      end
   end

   assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (access && mode.toggle && !sel_wr) |=> (sel != $past(sel)));

   assert_sel_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sel_wr |=> (sel == $past(sel_din)));

   assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode));
endmodule

// File: rtl/dptr_pair_bank.sv
module dptr_pair_bank
   import dpb_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned PTR_W   = 2 * DATA_W,
   parameter bit          ALT_MAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        sfr_addr,
   input  logic              sfr_wr,
   input  logic [DATA_W-1:0] sfr_wdata,
   output logic [DATA_W-1:0] sfr_rdata,
   output logic              sfr_hit,
   input  logic              req_inc,
   input  logic              req_dec,
   input  logic              req_store_inc,
   input  logic              req_access,
   output logic [PTR_W-1:0]  ptr_addr
);
   localparam int unsigned HI_W  = PTR_W - DATA_W;
   localparam int unsigned PAD_W = DATA_W - MODE_W;

   generate
      if (DATA_W < MODE_W) begin : g_bad_data
         $error("dptr_pair_bank: DATA_W too narrow for the mode field");
      end
      if (PTR_W != 2 * DATA_W) begin : g_bad_ptr
         $error("dptr_pair_bank: PTR_W must be twice DATA_W");
      end
   endgenerate

   logic               sel;
   dpb_mode_t          mode;
   logic               hit_lo, hit_hi, hit_p1lo, hit_p1hi, hit_sel, hit_mode;
   logic [NUM_PTR-1:0] wr_lo, wr_hi;
   logic               wr_sel, wr_mode;
   logic [NUM_PTR-1:0] step_en;
   logic [PTR_W-1:0]   ptr_val [NUM_PTR];
   logic [PTR_W-1:0]   step_val;
   logic [PTR_W-1:0]   step_mag;
   logic               step_any;

   dpb_decode #(.ALT_MAP(ALT_MAP)) u_dec (
      .addr    (sfr_addr),
      .wr      (sfr_wr),
      .sel     (sel),
      .hit_lo  (hit_lo),
      .hit_hi  (hit_hi),
      .hit_p1lo(hit_p1lo),
      .hit_p1hi(hit_p1hi),
      .hit_sel (hit_sel),
      .hit_mode(hit_mode),
      .hit_any (sfr_hit),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wr_sel  (wr_sel),
      .wr_mode (wr_mode)
   );

   dpb_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_wr  (wr_sel),
      .sel_din (sfr_wdata[0]),
      .mode_wr (wr_mode),
      .mode_din(sfr_wdata[MODE_W-1:0]),
      .access  (req_access),
      .sel     (sel),
      .mode    (mode)
   );

   // Step amount from the request kind and the mode register
   assign step_mag = mode.step2 ? PTR_W'(2) : PTR_W'(1);

   always_comb begin
      step_val = '0;
      step_any = 1'b0;
      if (req_inc || req_store_inc) begin
         step_val = PTR_W'(1);
         step_any = 1'b1;
      end else if (req_dec) begin
         step_val = '1;
         step_any = 1'b1;
      end else if (req_access && mode.auto_en) begin
         step_val = mode.down ? (PTR_W'(0) - step_mag) : step_mag;
         step_any = 1'b1;
      end
   end

   generate
      for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
         assign step_en[i] = step_any && (sel == 1'(i)) && !wr_lo[i] && !wr_hi[i];

         dpb_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (wr_lo[i]),
            .wr_hi   (wr_hi[i]),
            .wdata   (sfr_wdata),
            .step_en (step_en[i]),
            .step_val(step_val),
            .value   (ptr_val[i])
         );
      end
   endgenerate

   assign ptr_addr = sel ? ptr_val[1] : ptr_val[0];

   always_comb begin
      sfr_rdata = '0;
      if (hit_lo)        sfr_rdata = ptr_addr[DATA_W-1:0];
      else if (hit_hi)   sfr_rdata = DATA_W'(ptr_addr[PTR_W-1:DATA_W]);
      else if (hit_p1lo) sfr_rdata = ptr_val[1][DATA_W-1:0];
      else if (hit_p1hi) sfr_rdata = DATA_W'(ptr_val[1][PTR_W-1:DATA_W]);
      else if (hit_sel)  sfr_rdata = DATA_W'(sel);
      else if (hit_mode) sfr_rdata = {{PAD_W{1'b0}}, mode};
   end

   // Only the active pointer may move in one cycle
   assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(step_en));

   // Pointer 1 held while pointer 0 is active and pointer 1 is not written
   assert_inactive_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel && !wr_lo[1] && !wr_hi[1]) |=> (ptr_val[1] == $past(ptr_val[1])));

   // The standard high byte never reaches the inactive pointer
   assert_hi_routing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_wr && hit_hi && sel) |-> !wr_hi[0]);

   // An increment request moves the pointer shown at the port by one
   assert_inc_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_inc && !sfr_wr) |=> (ptr_addr == $past(ptr_addr) + PTR_W'(1)));

   // The block never claims the read data when it was not addressed
   always_comb begin
      if (rst_n && !sfr_hit)
         assert_no_stray_read_R11: assert (sfr_rdata == '0);
   end

   // Keep unused-width helpers referenced
   logic unused_hi;
   assign unused_hi = ^{HI_W{1'b0}};
endmodule

// File: tb/dptr_pair_bank_test.sv
module dptr_pair_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  sfr_addr = 8'h00;
   logic        sfr_wr = 1'b0;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        sfr_hit;
   logic        req_inc = 1'b0, req_dec = 1'b0, req_store_inc = 1'b0, req_access = 1'b0;
   logic [15:0] ptr_addr;

   logic [7:0]  alt_addr = 8'h00;
   logic        alt_wr = 1'b0;
   logic [7:0]  alt_wdata = 8'h00;
   logic [7:0]  alt_rdata;
   logic        alt_hit;
   logic [15:0] alt_ptr;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dptr_pair_bank uut (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit),
      .req_inc(req_inc), .req_dec(req_dec), .req_store_inc(req_store_inc),
      .req_access(req_access), .ptr_addr(ptr_addr)
   );

   dptr_pair_bank #(.ALT_MAP(1'b1)) uut_alt (
      .clk(clk), .rst_n(rst_n), .sfr_addr(alt_addr), .sfr_wr(alt_wr),
      .sfr_wdata(alt_wdata), .sfr_rdata(alt_rdata), .sfr_hit(alt_hit),
      .req_inc(1'b0), .req_dec(1'b0), .req_store_inc(1'b0),
      .req_access(1'b0), .ptr_addr(alt_ptr)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      sfr_addr = a;
      #1 d = sfr_rdata;
   endtask

   // kind: 0 inc, 1 dec, 2 store_inc, 3 access
   task automatic pulse(input int kind);
      @(negedge clk);
      req_inc = (kind == 0); req_dec = (kind == 1);
      req_store_inc = (kind == 2); req_access = (kind == 3);
      @(negedge clk);
      req_inc = 1'b0; req_dec = 1'b0; req_store_inc = 1'b0; req_access = 1'b0;
   endtask

   task automatic alt_wr_t(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      alt_addr = a; alt_wdata = d; alt_wr = 1'b1;
      @(negedge clk);
      alt_wr = 1'b0;
   endtask

   task automatic load(input logic [7:0] lo_a, input logic [7:0] hi_a, input logic [15:0] v);
      wr(lo_a, v[7:0]);
      wr(hi_a, v[15:8]);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R1 addr", ptr_addr, 16'h0000);
      rd(8'h86, d); check("R1 select", {8'h00, d}, 16'h0000);
      rd(8'h93, d); check("R1 mode", {8'h00, d}, 16'h0000);
      rd(8'h85, d); check("R1 p1 high", {8'h00, d}, 16'h0000);
   endtask

   task automatic t_select;
      logic [7:0] d;
      load(8'h82, 8'h83, 16'h1234);
      check("R3 p0 via std", ptr_addr, 16'h1234);
      wr(8'h86, 8'h01);
      load(8'h82, 8'h83, 16'hABCD);
      check("R2 select p1", ptr_addr, 16'hABCD);
      rd(8'h84, d); check("R4 p1 low alias", {8'h00, d}, 16'h00CD);
      wr(8'h86, 8'hFE);
      rd(8'h86, d); check("R2 upper bits ignored", {8'h00, d}, 16'h0000);
      check("R2 select p0", ptr_addr, 16'h1234);
      rd(8'h83, d); check("R3 std high reads p0", {8'h00, d}, 16'h0012);
      wr(8'h85, 8'h56);
      check("R4 alias leaves p0", ptr_addr, 16'h1234);
      wr(8'h86, 8'h01);
      check("R4 alias wrote p1", ptr_addr, 16'h56CD);
      wr(8'h86, 8'h00);
   endtask

   task automatic t_arith;
      load(8'h82, 8'h83, 16'hFFFF);
      pulse(0); check("R5 inc wraps", ptr_addr, 16'h0000);
      pulse(1); check("R6 dec wraps", ptr_addr, 16'hFFFF);
      wr(8'h93, 8'h07);
      pulse(2); check("R7 store_inc ignores mode", ptr_addr, 16'h0000);
      wr(8'h93, 8'h00);
   endtask

   task automatic t_mode;
      logic [7:0] d;
      load(8'h82, 8'h83, 16'h0100);
      pulse(3); check("R8 auto off", ptr_addr, 16'h0100);
      wr(8'h93, 8'h01); pulse(3); check("R8 up one", ptr_addr, 16'h0101);
      wr(8'h93, 8'h05); pulse(3); check("R8 up two", ptr_addr, 16'h0103);
      wr(8'h93, 8'h03); pulse(3); check("R8 down one", ptr_addr, 16'h0102);
      load(8'h82, 8'h83, 16'h0000);
      wr(8'h93, 8'h07); pulse(3); check("R8 down two wraps", ptr_addr, 16'hFFFE);
      wr(8'h93, 8'hFF);
      rd(8'h93, d); check("R8 readback", {8'h00, d}, 16'h000F);
      wr(8'h93, 8'h00);
   endtask

   task automatic t_toggle;
      logic [7:0] d;
      load(8'h82, 8'h83, 16'h0010);
      load(8'h84, 8'h85, 16'h0200);
      wr(8'h93, 8'h09);
      pulse(3); check("R9 toggle to p1", ptr_addr, 16'h0200);
      rd(8'h86, d); check("R9 select flipped", {8'h00, d}, 16'h0001);
      pulse(3); check("R9 back to stepped p0", ptr_addr, 16'h0011);
      rd(8'h84, d); check("R9 p1 stepped", {8'h00, d}, 16'h0001);
      wr(8'h93, 8'h00);
   endtask

   task automatic t_conflict;
      logic [7:0] d;
      load(8'h82, 8'h83, 16'h1234);
      @(negedge clk);
      sfr_addr = 8'h82; sfr_wdata = 8'h99; sfr_wr = 1'b1; req_inc = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0; req_inc = 1'b0;
      check("R10 write beats inc", ptr_addr, 16'h1299);
      wr(8'h93, 8'h08);
      @(negedge clk);
      sfr_addr = 8'h86; sfr_wdata = 8'h00; sfr_wr = 1'b1; req_access = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0; req_access = 1'b0;
      rd(8'h86, d); check("R10 select write beats toggle", {8'h00, d}, 16'h0000);
      check("R10 pointer unchanged", ptr_addr, 16'h1299);
      wr(8'h93, 8'h00);
   endtask

   task automatic t_hit;
      @(negedge clk);
      sfr_addr = 8'h84; #1 check("R11 hit own", {15'd0, sfr_hit}, 16'h0001);
      sfr_addr = 8'h81; #1 check("R11 no hit", {15'd0, sfr_hit}, 16'h0000);
      alt_wr_t(8'hA2, 8'h01);
      alt_wr_t(8'h84, 8'h77);
      check("R2 alt select", alt_ptr, 16'h0077);
      @(negedge clk);
      alt_addr = 8'h86; #1 check("R2 alt old addr unused", {15'd0, alt_hit}, 16'h0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_select();
      t_arith();
      t_mode();
      t_toggle();
      t_conflict();
      t_hit();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule